// File: doc/BRIEF.md
# Dual-Band Synthesizer Divider and Phase-Frequency Detector

This block is the digital core of a two-band frequency synthesizer. It runs on one system clock. Every oscillator edge reaches it as a one-cycle strobe: one strobe for the crystal, one for the high-band VCO and one for the low-band VCO. A programmable reference counter divides the crystal strobes. A band bit picks which VCO drives a programmable main counter. The high-band VCO first passes through a fixed divide-by-two prescaler, and the low-band VCO feeds the main counter directly.

A sequential three-state phase-frequency detector compares the two divided pulse trains. It produces pump-up and pump-down requests for an external charge pump. The core also gives a pump-enable for each band, a pump-current level bit, a polarity swap, a test mode that exposes the raw divided pulses, and a lock flag. The lock flag is based on how wide the detector pulses are, measured in crystal strobes.

Divisors are taken from live inputs only when a counter reaches its terminal count. Retuning therefore never produces a shortened or runt period.

Top module: `dbpll_core`

## Requirements
- R1: The reference counter emits a one-cycle pulse on the first crystal strobe after reset, then one pulse every `ref_div` strobes. A divisor of 0 or 1 behaves as 2, and any value up to 65535 is accepted.
- R2: The main counter behaves the same way with `main_div` applied to the selected VCO strobes. Two of its pulses are never in adjacent cycles.
- R3: With `band_low`=1, low-band strobes feed the main counter directly and high-band strobes are ignored. With `band_low`=0, only every second high-band strobe counted from reset (the 2nd, 4th, ...) reaches the main counter, and low-band strobes are ignored. `pump_en_hb` equals the inverse of `band_low` and `pump_en_lb` equals `band_low`.
- R4: With `test_mode`=0 and `pol_pos`=0, the pump-up and pump-down outputs are exchanged relative to `pol_pos`=1.
- R5: With `pol_pos`=1 and `test_mode`=0, a reference pulse raises `pump_up` in the next cycle, and a main pulse raises `pump_dn` in the next cycle. Each stays high until the other is also high. When both are high they are cleared in the following cycle. A pulse that arrives in that clearing cycle is kept.
- R6: With `test_mode`=1, `pump_up` carries the reference-counter pulse and `pump_dn` carries the main-counter pulse in the same cycle, with no polarity swap.
- R7: `pump_lvl1` follows `cur_lvl1`: 1 selects current level 1 and 0 selects current level 2.
- R8: `locked` rises one cycle after the fourth consecutive detector reset (`pump_up` and `pump_dn` both high) whose pulse width was below `lock_thr`. Pulse width is the number of crystal strobes seen while exactly one of the detector outputs is high.
- R9: While a pulse is in progress, `locked` falls one cycle after its width reaches `lock_thr`, and the run of good comparisons restarts.
- R10: A divisor written in mid-count takes effect only after the current count reaches terminal count.
- R11: During and straight after reset, `pump_up`, `pump_dn` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xtal_tick | input | 1 | Crystal edge strobe |
| vco_hb_tick | input | 1 | High-band VCO edge strobe |
| vco_lb_tick | input | 1 | Low-band VCO edge strobe |
| ref_div | input | 16 | Reference divisor |
| main_div | input | 16 | Main divisor |
| band_low | input | 1 | 1 = low band, 0 = high band |
| pol_pos | input | 1 | 1 = positive polarity, 0 = swapped |
| cur_lvl1 | input | 1 | 1 = pump level 1, 0 = level 2 |
| test_mode | input | 1 | 1 = route divided pulses to pump outputs |
| lock_thr | input | 8 | Lock pulse-width threshold in crystal strobes |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pump_en_hb | output | 1 | High-band pump enable |
| pump_en_lb | output | 1 | Low-band pump enable |
| pump_lvl1 | output | 1 | Pump current level select |
| locked | output | 1 | Lock indicator |

## Verification
Two events can fall in the same cycle: the detector clearing its two outputs and a new reference pulse arriving. The stimulus uses a reference divisor of 2. A low-band strobe is placed so that the main pulse raises `pump_dn` exactly as the reference counter reaches its next terminal count. The bench then requires both outputs high in one cycle and `pump_up` alone high in the next, which shows the new pulse was not lost. A second coincidence drives reference and main pulses in the same cycle. Both outputs must then rise together for one cycle and clear.

// File: rtl/dbpll_pkg.sv
package dbpll_pkg;
   typedef enum logic {
      BAND_HIGH = 1'b0,
      BAND_LOW  = 1'b1
   } band_e;

   localparam int MIN_DIVISOR = 2;
endpackage

// File: rtl/dbpll_divider.sv
module dbpll_divider #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] divisor,
   output logic         pulse
);
   import dbpll_pkg::*;

   localparam logic [W-1:0] FLOOR = W'(MIN_DIVISOR);
   localparam logic [W-1:0] ONE   = W'(1);

   logic [W-1:0] cnt;
   logic [W-1:0] load_val;

   // clamp illegal divisors; sampled only at terminal count
   always_comb load_val = (divisor < FLOOR) ? FLOOR : divisor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= ONE;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (tick) begin
            if (cnt == ONE) begin
               cnt   <= load_val;
               pulse <= 1'b1;
            end else begin
               cnt <= cnt - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/dbpll_prescaler.sv
module dbpll_prescaler #(
   parameter int LOG2 = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic tick_out
);
   generate
      if (LOG2 == 0) begin : g_bypass
         assign tick_out = tick;
      end else begin : g_div
         logic [LOG2-1:0] ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ph <= '0;
            else if (tick) ph <= ph + 1'b1;
         end
         assign tick_out = tick & (&ph);
      end
   endgenerate
endmodule

// File: rtl/dbpll_pfd.sv
module dbpll_pfd #(
   parameter int THR_W    = 8,
   parameter int LOCK_RUN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_p,
   input  logic             fb_p,
   input  logic             ref_tick,
   input  logic [THR_W-1:0] thr,
   output logic             up_q,
   output logic             dn_q,
   output logic             over_thr,
   output logic             locked
);
   localparam int GW = $clog2(LOCK_RUN + 1);
   localparam logic [GW-1:0] RUN_TOP  = GW'(LOCK_RUN);
   localparam logic [GW-1:0] RUN_LAST = GW'(LOCK_RUN - 1);

   logic [THR_W-1:0] wcnt;
   logic [GW-1:0]    good;
   logic             one_side;
   logic             both;

   assign one_side = up_q ^ dn_q;
   assign both     = up_q & dn_q;
   assign over_thr = (wcnt >= thr);

   // three-state detector: a pulse in the clearing cycle survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= ref_p | (up_q & ~dn_q);
         dn_q <= fb_p  | (dn_q & ~up_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt   <= '0;
         good   <= '0;
         locked <= 1'b0;
      end else if (one_side && over_thr) begin
         locked <= 1'b0;
         good   <= '0;
         if (ref_tick && wcnt != '1) wcnt <= wcnt + 1'b1;
      end else if (both) begin
         wcnt <= '0;
         if (over_thr) begin
            locked <= 1'b0;
            good   <= '0;
         end else begin
            if (good < RUN_TOP)    good   <= good + 1'b1;
            if (good >= RUN_LAST)  locked <= 1'b1;
         end
      end else if (one_side && ref_tick && wcnt != '1) begin
         wcnt <= wcnt + 1'b1;
      end
   end
endmodule

// File: rtl/dbpll_core.sv
module dbpll_core #(
   parameter int DIV_W       = 16,
   parameter int THR_W       = 8,
   parameter int LOCK_RUN    = 4,
   parameter int HB_PRE_LOG2 = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xtal_tick,
   input  logic             vco_hb_tick,
   input  logic             vco_lb_tick,
   input  logic [DIV_W-1:0] ref_div,
   input  logic [DIV_W-1:0] main_div,
   input  logic             band_low,
   input  logic             pol_pos,
   input  logic             cur_lvl1,
   input  logic             test_mode,
   input  logic [THR_W-1:0] lock_thr,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             pump_en_hb,
   output logic             pump_en_lb,
   output logic             pump_lvl1,
   output logic             locked
);
   import dbpll_pkg::*;

   initial begin
      if (DIV_W < 2)       $fatal(1, "DIV_W must be at least 2");
      if (THR_W < 1)       $fatal(1, "THR_W must be at least 1");
      if (LOCK_RUN < 1)    $fatal(1, "LOCK_RUN must be at least 1");
      if (HB_PRE_LOG2 < 0) $fatal(1, "HB_PRE_LOG2 must not be negative");
   end

   band_e band;
   logic  hb_div;
   logic  fb_tick;
   logic  ref_p;
   logic  fb_p;
   logic  up_q;
   logic  dn_q;
   logic  over_thr;

   assign band = band_e'(band_low);

   dbpll_prescaler #(.LOG2(HB_PRE_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(vco_hb_tick), .tick_out(hb_div)
   );

   assign fb_tick = (band == BAND_LOW) ? vco_lb_tick : hb_div;

   dbpll_divider #(.W(DIV_W)) u_ref (
      .clk(clk), .rst_n(rst_n), .tick(xtal_tick), .divisor(ref_div), .pulse(ref_p)
   );

   dbpll_divider #(.W(DIV_W)) u_main (
      .clk(clk), .rst_n(rst_n), .tick(fb_tick), .divisor(main_div), .pulse(fb_p)
   );

   dbpll_pfd #(.THR_W(THR_W), .LOCK_RUN(LOCK_RUN)) u_pfd (
      .clk(clk), .rst_n(rst_n), .ref_p(ref_p), .fb_p(fb_p), .ref_tick(xtal_tick),
      .thr(lock_thr), .up_q(up_q), .dn_q(dn_q), .over_thr(over_thr), .locked(locked)
   );

   always_comb begin
      if (test_mode) begin
         pump_up = ref_p;
         pump_dn = fb_p;
      end else if (pol_pos) begin
         pump_up = up_q;
         pump_dn = dn_q;
      end else begin
         pump_up = dn_q;
         pump_dn = up_q;
      end
   end

   assign pump_en_hb = (band == BAND_HIGH);
   assign pump_en_lb = (band == BAND_LOW);
   assign pump_lvl1  = cur_lvl1;
endmodule

// File: rtl/dbpll_core_chk.sv
module dbpll_core_chk (
   input logic clk,
   input logic rst_n,
   input logic xtal_tick,
   input logic vco_hb_tick,
   input logic vco_lb_tick,
   input logic band_low,
   input logic ref_p,
   input logic fb_p,
   input logic up_q,
   input logic dn_q,
   input logic over_thr,
   input logic locked
);
   p_ref_from_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ref_p |-> $past(xtal_tick));

   p_main_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fb_p |=> !fb_p);

   p_fb_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fb_p |-> $past(band_low ? vco_lb_tick : vco_hb_tick));

   p_pfd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && dn_q && !(ref_p && fb_p)) |=> !(up_q && dn_q));

   p_lock_on_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(up_q && dn_q));

   p_lock_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && over_thr && (up_q != dn_q)) |=> !locked);
endmodule

bind dbpll_core dbpll_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .vco_hb_tick(vco_hb_tick),
   .vco_lb_tick(vco_lb_tick), .band_low(band_low), .ref_p(ref_p), .fb_p(fb_p),
   .up_q(up_q), .dn_q(dn_q), .over_thr(over_thr), .locked(locked)
);

// File: tb/dbpll_core_test.sv
`timescale 1ns/1ps
module dbpll_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xtal_tick = 1'b0, vco_hb_tick = 1'b0, vco_lb_tick = 1'b0;
   logic [15:0] ref_div = 16'd2, main_div = 16'd2;
   logic        band_low = 1'b1, pol_pos = 1'b1, cur_lvl1 = 1'b0, test_mode = 1'b0;
   logic [7:0]  lock_thr = 8'd1;
   logic        pump_up, pump_dn, pump_en_hb, pump_en_lb, pump_lvl1, locked;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dbpll_core uut (
      .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .vco_hb_tick(vco_hb_tick),
      .vco_lb_tick(vco_lb_tick), .ref_div(ref_div), .main_div(main_div),
      .band_low(band_low), .pol_pos(pol_pos), .cur_lvl1(cur_lvl1),
      .test_mode(test_mode), .lock_thr(lock_thr), .pump_up(pump_up),
      .pump_dn(pump_dn), .pump_en_hb(pump_en_hb), .pump_en_lb(pump_en_lb),
      .pump_lvl1(pump_lvl1), .locked(locked)
   );

   // scenario table: divisors, band, expected pulse counts over 40 strobes
   localparam int NV = 6;
   localparam int V_R   [NV] = '{5, 5, 0, 2, 40, 13};
   localparam int V_N   [NV] = '{4, 4, 1, 3, 65535, 7};
   localparam int V_LOW [NV] = '{1, 0, 1, 0, 1, 0};
   localparam int V_UP  [NV] = '{8, 8, 20, 20, 1, 4};
   localparam int V_DN  [NV] = '{10, 5, 20, 7, 1, 3};

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic h, input logic l);
      @(negedge clk);
      xtal_tick = r; vco_hb_tick = h; vco_lb_tick = l;
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; xtal_tick = 0; vco_hb_tick = 0; vco_lb_tick = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int nup, ndn, nboth;
      // R11: reset state
      do_reset();
      #1;
      chk("R11 up", pump_up, 0);
      chk("R11 dn", pump_dn, 0);
      chk("R11 lock", locked, 0);

      // R7 / R3 enables
      band_low = 0; cur_lvl1 = 1; #1;
      chk("R3 en_hb", pump_en_hb, 1);
      chk("R3 en_lb", pump_en_lb, 0);
      chk("R7 lvl1", pump_lvl1, 1);
      band_low = 1; cur_lvl1 = 0; #1;
      chk("R3 en_lb", pump_en_lb, 1);
      chk("R7 lvl2", pump_lvl1, 0);

      // table: R1 R2 R3 R6 in test mode
      test_mode = 1;
      for (int v = 0; v < NV; v++) begin
         ref_div = 16'(V_R[v]); main_div = 16'(V_N[v]); band_low = V_LOW[v][0];
         do_reset();
         nup = 0; ndn = 0;
         for (int i = 0; i < 40; i++) begin
            cyc(1, 1, 1);
            nup += int'(pump_up); ndn += int'(pump_dn);
         end
         for (int i = 0; i < 2; i++) begin
            cyc(0, 0, 0);
            nup += int'(pump_up); ndn += int'(pump_dn);
         end
         chk("R1 ref pulses", nup, V_UP[v]);
         chk("R3 R2 main pulses", ndn, V_DN[v]);
      end

      // R10: retune mid-count, test mode
      ref_div = 16'd4; band_low = 1;
      do_reset();
      for (int i = 1; i <= 7; i++) begin
         if (i == 3) ref_div = 16'd2;
         cyc(1, 0, 0);
         chk($sformatf("R10 tick %0d", i), pump_up, (i == 1 || i == 5 || i == 7) ? 1 : 0);
      end

      // R5 positive polarity
      test_mode = 0; pol_pos = 1; ref_div = 16'd3; main_div = 16'd3;
      do_reset();
      cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R5 up set", pump_up, 1);
      chk("R5 dn idle", pump_dn, 0);
      cyc(0, 0, 1);
      cyc(0, 0, 0);
      chk("R5 both up", pump_up, 1);
      chk("R5 both dn", pump_dn, 1);
      cyc(0, 0, 0);
      chk("R5 cleared", pump_up | pump_dn, 0);

      // R4 negative polarity
      pol_pos = 0;
      do_reset();
      cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R4 swapped up", pump_up, 0);
      chk("R4 swapped dn", pump_dn, 1);

      // R5 coincidences
      pol_pos = 1; ref_div = 16'd2; main_div = 16'd2;
      do_reset();
      cyc(1, 0, 1);
      cyc(0, 0, 0);
      chk("R5 same cycle both", pump_up & pump_dn, 1);
      cyc(0, 0, 0);
      chk("R5 same cycle clear", pump_up | pump_dn, 0);
      do_reset();
      cyc(1, 0, 0);
      cyc(1, 0, 1);
      cyc(1, 0, 0);
      chk("R5 clear cycle both", pump_up & pump_dn, 1);
      cyc(0, 0, 0);
      chk("R5 kept pulse up", pump_up, 1);
      chk("R5 kept pulse dn", pump_dn, 0);

      // R8 / R9 lock
      lock_thr = 8'd1;
      do_reset();
      nboth = 0;
      for (int i = 0; i < 30 && nboth < 4; i++) begin
         cyc(1, 0, 1);
         if (pump_up && pump_dn) nboth++;
         if (nboth < 4) chk("R8 not yet locked", locked, 0);
      end
      chk("R8 fourth compare", nboth, 4);
      chk("R8 lock before", locked, 0);
      cyc(1, 0, 1);
      chk("R8 lock asserted", locked, 1);
      for (int i = 0; i < 8; i++) cyc(1, 0, 0);
      chk("R9 lock dropped", locked, 0);
      chk("R5 up held", pump_up, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule